// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which oscillator drives the system clock. Software presents a two-bit source code and a bit that picks the flavour of the low-frequency source. The block turns these into a committed active source, a select for the clock multiplexer, and three read-only "running at" flags. The three candidate sources are the 16 MHz crystal, the 16 MHz RC oscillator and a 32 kHz source. The 32 kHz source is either an RC oscillator or a 32 kHz crystal.

The block also owns the crystal-off control bit. It guards the two ways the system could lock up. It never lets the crystal be turned off while the crystal drives the system. It never moves onto the crystal before the crystal reports both settling and trimming done. A request that cannot be honoured yet is held pending, and the current source keeps running. Everything is modelled as synchronous logic in one control clock domain with an active-high synchronous reset. The glitch-free switching cells and the oscillators are outside the block.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the active source is the RC16M oscillator: `run_at_rc16`=1, `run_at_xtal`=0, `run_at_lf`=0, `sys_mux_sel`=1, `xtal_off_state`=0, `switch_pending`=0, and `xtal_osc_en`=1 when not asleep.
- R2: Source code 1 selects RC16M, and codes 2 and 3 both select the 32 kHz source. A change of source class commits on the first clock edge at which it is presented.
- R3: `sys_mux_sel` encodes 0 = 16 MHz crystal, 1 = RC16M, 2 = 32 kHz RC, 3 = 32 kHz crystal. The 32 kHz flavour is taken from `lf_src_xtal` (0 RC, 1 crystal) at the committing edge.
- R4: While running at 32 kHz, changing `lf_src_xtal` or moving between codes 2 and 3 leaves `sys_mux_sel` unchanged until the next committed switch.
- R5: Code 0 commits to the crystal only at an edge where `xtal_settled`=1, `xtal_trim_ready`=1 and the crystal-off bit is clear. Until then the current source stays active and `switch_pending`=1.
- R6: A write (`xtal_off_wr`=1) stores `xtal_off_wdata` into the crystal-off bit, shown on `xtal_off_state` after the edge. While that bit is set, `xtal_osc_en`=0.
- R7: A write of 1 is ignored while `run_at_xtal`=1. A write of 1 presented in the same cycle as a crystal-ready code 0 is accepted, and it blocks that commit.
- R8: `xtal_osc_en`=0 while `sleep_active`=1. After wakeup, the crystal stays disabled if the crystal-off bit is set, because sleep does not change that bit.
- R9: Exactly one running flag is set at any time. The flags and `sys_mux_sel` both come from the committed source, never from the raw code.
- R10: `switch_pending` is 0 whenever the requested class equals the committed class. It falls at the edge where the crystal commit happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Requested source code |
| lf_src_xtal | input | 1 | 32 kHz flavour: 0 RC, 1 crystal |
| xtal_off_wr | input | 1 | Write strobe for the crystal-off bit |
| xtal_off_wdata | input | 1 | Value written to the crystal-off bit |
| xtal_settled | input | 1 | Crystal settling time elapsed |
| xtal_trim_ready | input | 1 | Crystal trim applied |
| sleep_active | input | 1 | System is in sleep |
| sys_mux_sel | output | 2 | Clock multiplexer select |
| run_at_lf | output | 1 | Running at a 32 kHz source |
| run_at_rc16 | output | 1 | Running at RC16M |
| run_at_xtal | output | 1 | Running at the 16 MHz crystal |
| xtal_osc_en | output | 1 | Enable to the 16 MHz crystal oscillator |
| xtal_off_state | output | 1 | Read-back of the crystal-off bit |
| switch_pending | output | 1 | Crystal request waiting for readiness |

## Verification
A corrupted committed-source register shows at the ports straight away. `sys_mux_sel` and the running flags are a pure decode of that register, so the wrong value appears in the same cycle, right after the edge that loaded it. A corrupted crystal-off bit shows straight away on `xtal_off_state` and `xtal_osc_en`. Its more dangerous effect appears later: a commit to the crystal is wrongly blocked or allowed at the next edge where code 0 is presented with both ready flags high. That case is exercised in the same cycle as a disable write.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int SEL_W = 2;
    localparam int MUX_W = 2;

    typedef enum logic [1:0] {
        CLS_XTAL = 2'd0,
        CLS_RC16 = 2'd1,
        CLS_LF   = 2'd2
    } src_cls_e;

    typedef enum logic [MUX_W-1:0] {
        MUX_XTAL16  = 2'd0,
        MUX_RC16    = 2'd1,
        MUX_RC32K   = 2'd2,
        MUX_XTAL32K = 2'd3
    } mux_sel_e;

    typedef struct packed {
        src_cls_e cls;
        logic     lf_xtal;
    } act_src_t;

    typedef struct packed {
        logic at_xtal;
        logic at_rc16;
        logic at_lf;
    } run_flags_t;

    localparam act_src_t RESET_SRC = '{cls: CLS_RC16, lf_xtal: 1'b0};

    function automatic src_cls_e cls_of_code(input logic [SEL_W-1:0] code);
        case (code)
            2'd0:    return CLS_XTAL;
            2'd1:    return CLS_RC16;
            default: return CLS_LF;
        endcase
    endfunction

    function automatic mux_sel_e mux_of(input act_src_t a);
        case (a.cls)
            CLS_XTAL: return MUX_XTAL16;
            CLS_LF:   return a.lf_xtal ? MUX_XTAL32K : MUX_RC32K;
            default:  return MUX_RC16;
        endcase
    endfunction

endpackage

// File: rtl/xtal_guard.sv
module xtal_guard
    import clksw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic off_wr,
    input  logic off_wdata,
    input  logic running_xtal,
    input  logic settled,
    input  logic trim_ready,
    input  logic asleep,
    output logic off_q,
    output logic osc_en,
    output logic xtal_ready
);
    // The off bit is kept through sleep; only reset or a write changes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= 1'b0;
        end else if (off_wr) begin
            if (!(off_wdata && running_xtal)) begin
                off_q <= off_wdata;
            end
        end
    end

    always_comb begin
        osc_en     = !off_q && !asleep;
        xtal_ready = settled && trim_ready && !off_q;
    end
endmodule

// File: rtl/src_arbiter.sv
module src_arbiter
    import clksw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] code,
    input  logic             lf_xtal_sel,
    input  logic             xtal_ready,
    input  logic             off_set_req,
    output act_src_t         act,
    output logic             pending
);
    act_src_t act_q;
    src_cls_e want;
    logic     differ;
    logic     allow;
    logic     commit;

    always_comb begin
        want   = cls_of_code(code);
        differ = (want != act_q.cls);
        allow  = (want != CLS_XTAL) || (xtal_ready && !off_set_req);
        commit = differ && allow;
        pending = differ && !allow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= RESET_SRC;
        end else if (commit) begin
            act_q.cls     <= want;
            act_q.lf_xtal <= lf_xtal_sel;
        end
    end

    assign act = act_q;
endmodule

// File: rtl/status_decode.sv
module status_decode
    import clksw_pkg::*;
(
    input  act_src_t         act,
    output run_flags_t       flags,
    output logic [MUX_W-1:0] mux_sel
);
    always_comb begin
        flags.at_xtal = (act.cls == CLS_XTAL);
        flags.at_rc16 = (act.cls == CLS_RC16);
        flags.at_lf   = (act.cls == CLS_LF);
        mux_sel       = mux_of(act);
    end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clksw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             lf_src_xtal,
    input  logic             xtal_off_wr,
    input  logic             xtal_off_wdata,
    input  logic             xtal_settled,
    input  logic             xtal_trim_ready,
    input  logic             sleep_active,
    output logic [MUX_W-1:0] sys_mux_sel,
    output logic             run_at_lf,
    output logic             run_at_rc16,
    output logic             run_at_xtal,
    output logic             xtal_osc_en,
    output logic             xtal_off_state,
    output logic             switch_pending
);
    act_src_t   act;
    run_flags_t flags;
    logic       ready;

    xtal_guard u_guard (
        .clk          (clk),
        .rst          (rst),
        .off_wr       (xtal_off_wr),
        .off_wdata    (xtal_off_wdata),
        .running_xtal (flags.at_xtal),
        .settled      (xtal_settled),
        .trim_ready   (xtal_trim_ready),
        .asleep       (sleep_active),
        .off_q        (xtal_off_state),
        .osc_en       (xtal_osc_en),
        .xtal_ready   (ready)
    );

    src_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .code        (src_sel),
        .lf_xtal_sel (lf_src_xtal),
        .xtal_ready  (ready),
        .off_set_req (xtal_off_wr && xtal_off_wdata),
        .act         (act),
        .pending     (switch_pending)
    );

    status_decode u_dec (
        .act     (act),
        .flags   (flags),
        .mux_sel (sys_mux_sel)
    );

    assign run_at_lf   = flags.at_lf;
    assign run_at_rc16 = flags.at_rc16;
    assign run_at_xtal = flags.at_xtal;
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
    input logic       clk,
    input logic       rst,
    input logic       xtal_off_wr,
    input logic       xtal_off_wdata,
    input logic       xtal_settled,
    input logic       xtal_trim_ready,
    input logic       sleep_active,
    input logic [1:0] sys_mux_sel,
    input logic       run_at_lf,
    input logic       run_at_rc16,
    input logic       run_at_xtal,
    input logic       xtal_osc_en,
    input logic       xtal_off_state,
    input logic       switch_pending
);
    // R9
    onehot_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({run_at_lf, run_at_rc16, run_at_xtal}));

    // R7
    no_off_while_xtal_chk: assert property (@(posedge clk) disable iff (rst)
        run_at_xtal |-> !xtal_off_state);

    // R7
    reject_off_write_chk: assert property (@(posedge clk) disable iff (rst)
        (run_at_xtal && xtal_off_wr && xtal_off_wdata) |=> !xtal_off_state);

    // R5
    xtal_ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_at_xtal && !(xtal_settled && xtal_trim_ready)) |=> !run_at_xtal);

    // R6
    off_gates_osc_chk: assert property (@(posedge clk) disable iff (rst)
        xtal_off_state |-> !xtal_osc_en);

    // R8
    sleep_gates_osc_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> !xtal_osc_en);

    // R4
    lf_flavour_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_at_lf |=> (run_at_lf -> $stable(sys_mux_sel)));

    // R10
    pending_not_xtal_chk: assert property (@(posedge clk) disable iff (rst)
        switch_pending |-> !run_at_xtal);
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .xtal_off_wr     (xtal_off_wr),
    .xtal_off_wdata  (xtal_off_wdata),
    .xtal_settled    (xtal_settled),
    .xtal_trim_ready (xtal_trim_ready),
    .sleep_active    (sleep_active),
    .sys_mux_sel     (sys_mux_sel),
    .run_at_lf       (run_at_lf),
    .run_at_rc16     (run_at_rc16),
    .run_at_xtal     (run_at_xtal),
    .xtal_osc_en     (xtal_osc_en),
    .xtal_off_state  (xtal_off_state),
    .switch_pending  (switch_pending)
);

// File: tb/tb_clk_src_switch.sv
module tb_clk_src_switch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd1;
    logic       lf_src_xtal = 1'b0;
    logic       xtal_off_wr = 1'b0;
    logic       xtal_off_wdata = 1'b0;
    logic       xtal_settled = 1'b0;
    logic       xtal_trim_ready = 1'b0;
    logic       sleep_active = 1'b0;
    logic [1:0] sys_mux_sel;
    logic       run_at_lf, run_at_rc16, run_at_xtal;
    logic       xtal_osc_en, xtal_off_state, switch_pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    clk_src_switch dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .lf_src_xtal(lf_src_xtal),
        .xtal_off_wr(xtal_off_wr), .xtal_off_wdata(xtal_off_wdata),
        .xtal_settled(xtal_settled), .xtal_trim_ready(xtal_trim_ready),
        .sleep_active(sleep_active), .sys_mux_sel(sys_mux_sel),
        .run_at_lf(run_at_lf), .run_at_rc16(run_at_rc16), .run_at_xtal(run_at_xtal),
        .xtal_osc_en(xtal_osc_en), .xtal_off_state(xtal_off_state),
        .switch_pending(switch_pending)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // one rising edge; inputs were changed at a falling edge, sample at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // flags packed as {xtal, rc16, lf}
    function automatic int flags();
        return {run_at_xtal, run_at_rc16, run_at_lf};
    endfunction

    task automatic t_reset();
        check("R1 flags", flags(), 3'b010);
        check("R1 mux", sys_mux_sel, 1);
        check("R1 off", xtal_off_state, 0);
        check("R1 osc_en", xtal_osc_en, 1);
        check("R1 pending", switch_pending, 0);
    endtask

    task automatic t_rc_lf();
        src_sel = 2'd2; lf_src_xtal = 1'b0; step();
        check("R2 code2 flags", flags(), 3'b001);
        check("R3 rc32k mux", sys_mux_sel, 2);
        src_sel = 2'd3; lf_src_xtal = 1'b1; step();
        check("R4 code3 at lf keeps mux", sys_mux_sel, 2);
        src_sel = 2'd1; step();
        check("R2 back to rc16", flags(), 3'b010);
        src_sel = 2'd3; step();
        check("R9 flags lf", flags(), 3'b001);
        check("R3 xtal32k mux", sys_mux_sel, 3);
    endtask

    task automatic t_lf_flavour();
        lf_src_xtal = 1'b0; step();
        check("R4 flavour change held", sys_mux_sel, 3);
        src_sel = 2'd1; step();
        src_sel = 2'd2; step();
        check("R4 flavour taken at commit", sys_mux_sel, 2);
        src_sel = 2'd1; step();
    endtask

    task automatic t_xtal_gate();
        src_sel = 2'd0; xtal_settled = 1'b1; xtal_trim_ready = 1'b0; step();
        check("R5 trim missing flags", flags(), 3'b010);
        check("R5 pending", switch_pending, 1);
        xtal_settled = 1'b0; xtal_trim_ready = 1'b1; step();
        check("R5 settle missing flags", flags(), 3'b010);
        xtal_settled = 1'b1; step();
        check("R5 commit xtal", flags(), 3'b100);
        check("R3 mux xtal", sys_mux_sel, 0);
        check("R10 pending cleared", switch_pending, 0);
    endtask

    task automatic t_reject();
        xtal_off_wr = 1'b1; xtal_off_wdata = 1'b1; step();
        xtal_off_wr = 1'b0;
        check("R7 off rejected", xtal_off_state, 0);
        check("R7 osc stays on", xtal_osc_en, 1);
        check("R7 still xtal", flags(), 3'b100);
        src_sel = 2'd1; step();
        check("R2 leave xtal", flags(), 3'b010);
    endtask

    task automatic t_disable();
        src_sel = 2'd0; xtal_off_wr = 1'b1; xtal_off_wdata = 1'b1; step();
        xtal_off_wr = 1'b0;
        check("R7 same-cycle off accepted", xtal_off_state, 1);
        check("R7 same-cycle commit blocked", flags(), 3'b010);
        check("R6 osc off", xtal_osc_en, 0);
        step();
        check("R5 off bit blocks xtal", flags(), 3'b010);
        check("R5 pending while off", switch_pending, 1);
        xtal_off_wr = 1'b1; xtal_off_wdata = 1'b0; step();
        xtal_off_wr = 1'b0;
        check("R6 off cleared", xtal_off_state, 0);
        check("R6 osc on", xtal_osc_en, 1);
        check("R5 no commit on clearing edge", flags(), 3'b010);
        step();
        check("R5 commit after clear", flags(), 3'b100);
        src_sel = 2'd1; step();
    endtask

    task automatic t_sleep();
        xtal_off_wr = 1'b1; xtal_off_wdata = 1'b1; step();
        xtal_off_wr = 1'b0;
        sleep_active = 1'b1; step();
        check("R8 asleep osc", xtal_osc_en, 0);
        sleep_active = 1'b0; step();
        check("R8 wake keeps osc off", xtal_osc_en, 0);
        check("R8 off bit kept", xtal_off_state, 1);
        xtal_off_wr = 1'b1; xtal_off_wdata = 1'b0; step();
        xtal_off_wr = 1'b0;
        sleep_active = 1'b1; step();
        check("R8 asleep with bit clear", xtal_osc_en, 0);
        sleep_active = 1'b0; step();
        check("R8 wake osc on", xtal_osc_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_rc_lf();
        t_lf_flavour();
        t_xtal_gate();
        t_reject();
        t_disable();
        t_sleep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual 0 expected 1");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule